// File: doc/BRIEF.md
# Change-Only Logic Event Recorder

The recorder watches a small group of digital lines and samples them once per sample tick. A sample that equals the previous reference value is discarded. A sample that differs becomes an event. The event carries the new line values and the number of ticks that have elapsed since the last event. Events collect in a ring buffer, which absorbs bursts that arrive faster than the downstream link can carry them. A serialiser then drains each event as a short run of bytes on a valid/ready stream, and a serial transmitter consumes that stream at its own pace.

The channel count is a parameter and may be 2, 4 or 8. It fixes the event length at 1, 2 or 3 bytes. The line values sit in the top bits of the event word, and the interval fills all remaining bits. Long quiet periods are not lost. When the interval would run past its largest value, a filler event repeats the current lines with the largest interval, so summing the intervals always gives elapsed time. If an event arrives while the buffer is full, it is dropped and a sticky overflow flag is raised. Only the restart input clears that flag.

Top module: `chg_event_recorder`

## Requirements
- R1: During and right after synchronous active-low reset, out_valid and overflow are 0.
- R2: An event is a word of 8*NB bits, where NB = 1, 2 or 3 for CHANNELS = 2, 4 or 8. The word is {lines[CHANNELS-1:0], interval[IW-1:0]} with IW = 8*NB-CHANNELS, and it is sent most significant byte first. With 4 channels the first byte is {lines[3:0], interval[11:8]} and the second byte is interval[7:0].
- R3: A tick whose synchronised sample equals the reference value produces no event, unless the filler rule of R5 applies.
- R4: The interval of an event equals the number of ticks since the previous event, counting the current tick, and lies in 1..2^IW-1. The first event counts from reset.
- R5: After 2^IW-1 ticks without a change, a filler event carries the unchanged lines and interval 2^IW-1.
- R6: After reset the reference value is all zeros. The first tick that sees any line high produces an event.
- R7: Events are delivered in the order they were recorded. Up to DEPTH events are held in the ring, in addition to the one being serialised.
- R8: An event that finds the ring full is dropped and sets overflow. Overflow then stays 1. The dropped event still becomes the new reference and restarts the interval.
- R9: A cycle with restart high clears overflow on the next edge.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data keeps its value.
- R11: With the recorder idle, the first byte of an event is on out_data with out_valid high two edges after the edge that samples the tick. It is not valid one edge after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle strobe: take a sample this cycle |
| restart | input | 1 | Clears the overflow flag |
| lines_in | input | CHANNELS | Asynchronous monitored lines |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Consumer accepts the byte |
| overflow | output | 1 | Sticky: an event was dropped |

## Verification
A line change reaches the comparison two edges after it is driven, because it passes through the synchroniser. The bench therefore holds each new line value for three cycles before it raises the tick. The timing after a tick is fixed. The event register loads on the tick edge, the ring on the next edge, and the serialiser one edge after that. The latency checks sample out_valid 1 ns after the first and second edges that follow the tick edge. All other stream checks collect bytes at the falling edge whenever valid and ready are both high. Each collected byte is compared against a queue that the bench builds arithmetically from the tick and line history. Overflow and restart are sampled one cycle after the edge that sets or clears them.

// File: rtl/evr_pkg.sv
// Shared helpers for the change-only event recorder.
// Assumes channel counts of 2, 4 or 8; any other value maps to the next size up.
package evr_pkg;
    // Number of stream bytes an event occupies for a given channel count.
    function automatic int evr_bytes(input int channels);
        if (channels <= 2) return 1;
        else if (channels <= 4) return 2;
        else return 3;
    endfunction
endpackage

// File: rtl/evr_sync.sv
// Two-flop synchroniser, one chain per monitored line.
// Assumes the lines are quasi-static compared to the clock; gives no bus coherency.
module evr_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_chain
            logic meta_q, stable_q;
            // Two registers per line to settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q   <= 1'b0;
                    stable_q <= 1'b0;
                end else begin
                    meta_q   <= async_in[i];
                    stable_q <= meta_q;
                end
            end
            assign sync_out[i] = stable_q;
        end
    endgenerate
endmodule

// File: rtl/evr_detect.sv
// Change detector and interval counter.
// On each tick it compares the sample with the reference. A difference, or an
// interval reaching its maximum, produces a registered event word {lines, interval}.
// Assumes the tick is a single-cycle strobe; the reference resets to zero.
module evr_detect #(
    parameter int CHANNELS = 8,
    parameter int IW       = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [CHANNELS-1:0]    lines,
    output logic                   ev_valid,
    output logic [CHANNELS+IW-1:0] ev_word
);
    localparam logic [IW-1:0] MAXIV   = '1;
    localparam logic [IW-1:0] LASTCNT = MAXIV - 1'b1;

    logic [CHANNELS-1:0] ref_q;
    logic [IW-1:0]       cnt_q;

    // Per tick: emit on change or counter limit, otherwise count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q    <= '0;
            cnt_q    <= '0;
            ev_valid <= 1'b0;
            ev_word  <= '0;
        end else begin
            ev_valid <= 1'b0;
            if (tick) begin
                if (lines != ref_q || cnt_q == LASTCNT) begin
                    ev_valid <= 1'b1;
                    ev_word  <= {lines, cnt_q + 1'b1};
                    ref_q    <= lines;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R4: an event never carries a zero interval
    assert_interval_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> ev_word[IW-1:0] != '0);

    // R3: no tick, no event
    assert_no_event_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !ev_valid);

    // R5: an event with an interval below the maximum reports a change
    assert_change_or_filler_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_word[IW-1:0] != MAXIV |-> ev_word[CHANNELS+IW-1:IW] != $past(ref_q));
endmodule

// File: rtl/evr_ring.sv
// Ring buffer of event words with drop-on-full and a sticky overflow flag.
// Assumes DEPTH >= 2. A push that finds the ring full is discarded even when a
// pop happens in the same cycle. A drop outranks a restart in the same cycle.
module evr_ring #(
    parameter int WW    = 24,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [WW-1:0] push_word,
    input  logic          pop,
    input  logic          restart,
    output logic [WW-1:0] head_word,
    output logic          nonempty,
    output logic          overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULLC = (AW + 1)'(DEPTH);

    logic [WW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [AW:0]   count_q;
    logic          full, push_ok, pop_ok;

    assign full      = (count_q == FULLC);
    assign nonempty  = (count_q != '0);
    assign push_ok   = push && !full;
    assign pop_ok    = pop && nonempty;
    assign head_word = mem[rptr_q];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q] <= push_word;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wptr_q <= (wptr_q == LASTP) ? '0 : wptr_q + 1'b1;
            if (pop_ok)  rptr_q <= (rptr_q == LASTP) ? '0 : rptr_q + 1'b1;
            count_q <= count_q + (push_ok ? 1'b1 : 1'b0) - (pop_ok ? 1'b1 : 1'b0);
        end
    end

    // Sticky overflow: set by a drop, cleared by restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                 overflow <= 1'b0;
        else if (push && full)      overflow <= 1'b1;
        else if (restart)           overflow <= 1'b0;
    end

    // R7: occupancy never exceeds the depth
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULLC);

    // R8: a push into a full ring raises overflow
    assert_drop_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push && full |=> overflow);

    // R8: overflow holds until restart
    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !restart |=> overflow);

    // R9: a restart without a drop clears the flag
    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart && !(push && full) |=> !overflow);
endmodule

// File: rtl/evr_serial.sv
// Byte serialiser: takes one event word from the ring and presents its bytes,
// most significant first, on a valid/ready stream. It loads the next word in
// the same cycle that the last byte is accepted, so the stream has no gap.
// Assumes the head word is valid whenever nonempty is high.
module evr_serial #(
    parameter int NB = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [8*NB-1:0] head_word,
    input  logic            nonempty,
    output logic            pop,
    output logic [7:0]      out_data,
    output logic            out_valid,
    input  logic            out_ready
);
    localparam int WW   = 8 * NB;
    localparam int IDXW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IDXW-1:0] LASTB = IDXW'(NB - 1);

    logic [WW-1:0]   sh_q;
    logic [IDXW-1:0] idx_q;
    logic            busy_q, take;

    assign take      = !busy_q || (out_ready && idx_q == LASTB);
    assign pop       = take && nonempty;
    assign out_valid = busy_q;
    assign out_data  = sh_q[WW-1 -: 8];

    // Load a word or advance one byte on each accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            sh_q   <= '0;
        end else if (take) begin
            busy_q <= nonempty;
            if (nonempty) begin
                sh_q  <= head_word;
                idx_q <= '0;
            end
        end else if (out_ready) begin
            sh_q  <= sh_q << 8;
            idx_q <= idx_q + 1'b1;
        end
    end

    // R10: a byte offered but not accepted is held unchanged
    assert_hold_while_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/chg_event_recorder.sv
// Top of the change-only event recorder.
// Chain: synchroniser -> change detector -> ring buffer -> byte serialiser.
// Assumes sample_tick is a single-cycle strobe and CHANNELS is 2, 4 or 8.
module chg_event_recorder #(
    parameter int CHANNELS = 8,
    parameter int DEPTH    = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_tick,
    input  logic                restart,
    input  logic [CHANNELS-1:0] lines_in,
    output logic [7:0]          out_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                overflow
);
    import evr_pkg::*;

    localparam int NB = evr_bytes(CHANNELS);
    localparam int WW = 8 * NB;
    localparam int IW = WW - CHANNELS;

    logic [CHANNELS-1:0] lines_s;
    logic                ev_valid, nonempty, pop;
    logic [WW-1:0]       ev_word, head_word;

    evr_sync #(.WIDTH(CHANNELS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(lines_in), .sync_out(lines_s)
    );

    evr_detect #(.CHANNELS(CHANNELS), .IW(IW)) u_detect (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .lines(lines_s),
        .ev_valid(ev_valid), .ev_word(ev_word)
    );

    evr_ring #(.WW(WW), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .push(ev_valid), .push_word(ev_word),
        .pop(pop), .restart(restart), .head_word(head_word),
        .nonempty(nonempty), .overflow(overflow)
    );

    evr_serial #(.NB(NB)) u_serial (
        .clk(clk), .rst_n(rst_n), .head_word(head_word), .nonempty(nonempty),
        .pop(pop), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    // R1: nothing is offered in the cycle after a reset cycle
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !overflow);
endmodule

// File: tb/sim_chg_event_recorder.sv
// Bench: 4 channels (2-byte events, 12-bit interval), ring depth 4.
module sim_chg_event_recorder;
    localparam int CH    = 4;
    localparam int DEPTH = 4;
    localparam int MAXIV = 4095;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_tick = 1'b0;
    logic          restart = 1'b0;
    logic [CH-1:0] lines_in = '0;
    logic [7:0]    out_data;
    logic          out_valid, overflow;
    logic          out_ready = 1'b0;
    int            rdy_mode = 0;   // 0 always ready, 1 never, 2 toggle

    int checks = 0, errors = 0;
    bit done = 0;
    byte unsigned got[$], exp[$];
    int  tcnt = 0;
    logic [CH-1:0] refv = '0;
    bit  track = 0;
    int  inflight = 0;
    bit  exp_ovf = 0;

    always #10 clk = ~clk;

    chg_event_recorder #(.CHANNELS(CH), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .restart(restart),
        .lines_in(lines_in), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .overflow(overflow)
    );

    always @(posedge clk) begin
        #1;
        if (rdy_mode == 0) out_ready = 1'b1;
        else if (rdy_mode == 1) out_ready = 1'b0;
        else out_ready = ~out_ready;
    end

    always @(negedge clk)
        if (rst_n && out_valid && out_ready) got.push_back(out_data);

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic emit(input logic [CH-1:0] v, input int iv);
        logic [15:0] w;
        if (track && inflight >= DEPTH + 1) begin
            exp_ovf = 1;
        end else begin
            w = {v, 12'(iv)};
            exp.push_back(w[15:8]);
            exp.push_back(w[7:0]);
            if (track) inflight++;
        end
    endtask

    task automatic model_tick(input logic [CH-1:0] v);
        tcnt++;
        if (v != refv || tcnt == MAXIV) begin
            emit(v, tcnt);
            tcnt = 0;
            refv = v;
        end
    endtask

    task automatic tick_lines(input logic [CH-1:0] v);
        lines_in = v;
        repeat (3) @(posedge clk);
        #1 sample_tick = 1'b1;
        @(posedge clk);
        #1 sample_tick = 1'b0;
        model_tick(v);
    endtask

    task automatic hold_ticks(input int n);
        #1 sample_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 sample_tick = 1'b0;
        for (int i = 0; i < n; i++) model_tick(lines_in);
    endtask

    task automatic check_stream(input string req);
        int w = 0;
        while (got.size() < exp.size() && w < 5000) begin
            @(posedge clk);
            w++;
        end
        repeat (20) @(posedge clk);
        check({req, " byte count"}, got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            check(req, got[i], exp[i]);
        got.delete();
        exp.delete();
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] w0;
        repeat (4) @(posedge clk);
        #2;
        check("R1 out_valid in reset", out_valid, 0);
        check("R1 overflow in reset", overflow, 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);

        // R11 latency and R6 first event from the zero reference
        lines_in = 4'hA;
        repeat (3) @(posedge clk);
        #1 sample_tick = 1'b1;
        @(posedge clk);
        #1 sample_tick = 1'b0;
        model_tick(4'hA);
        w0 = {4'hA, 12'd1};
        @(posedge clk);
        #1 check("R11 not valid one edge after", out_valid, 0);
        @(posedge clk);
        #1 check("R11 valid two edges after", out_valid, 1);
        check("R11 first byte", out_data, w0[15:8]);
        check_stream("R6 first event");

        // R2 R3 R4: exhaustive pairs of line values with repeated samples
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                tick_lines(CH'(a));
                tick_lines(CH'(b));
                if ((a + b) % 3 == 0) tick_lines(CH'(b));
            end
        check_stream("R2 R3 R4 sweep");

        // R7 order under a toggling ready
        rdy_mode = 2;
        for (int a = 0; a < 32; a++) tick_lines(CH'((a * 7) % 16));
        check_stream("R7 toggling ready");
        rdy_mode = 0;

        // R3: many unchanged ticks below the limit produce nothing
        hold_ticks(100);
        check_stream("R3 unchanged");

        // R5: fillers after the interval limit
        hold_ticks(2 * MAXIV + 17);
        check_stream("R5 filler");
        check("R8 no overflow before fill", overflow, 0);

        // R8 R10: fill with ready low
        rdy_mode = 1;
        repeat (3) @(posedge clk);
        track = 1; inflight = 0; exp_ovf = 0;
        for (int a = 0; a < DEPTH + 3; a++) tick_lines(CH'(a % 2 ? 4'h5 : 4'h9));
        repeat (3) @(posedge clk);
        #1 check("R8 overflow set", overflow, exp_ovf);
        w0[7:0] = out_data;
        repeat (6) @(posedge clk);
        #1 check("R10 valid held", out_valid, 1);
        check("R10 data held", out_data, w0[7:0]);
        track = 0;
        rdy_mode = 0;
        check_stream("R7 R8 drain after drop");
        #1 check("R8 overflow sticky", overflow, 1);

        // R9 restart
        @(posedge clk);
        #1 restart = 1'b1;
        @(posedge clk);
        #1 restart = 1'b0;
        check("R9 overflow cleared", overflow, 0);
        tick_lines(4'h3);
        check_stream("R8 after drop interval");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule